// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter with Bypass

This block turns two parallel stereo words (left and right, from an upstream delay store) back into a serial audio stream. It is a slave: the bit clock and the frame clock come from outside, and the framing follows the same format selection used on the receive side. Three framings are offered: left-justified, right-justified and the two-wire I2S convention. Each runs either as 24-bit words in 32-clock half-frames or as 16-bit words in 16-clock half-frames. Data goes out MSB first, and each new bit is launched on the falling bit-clock edge so that a downstream receiver can capture it on the rising edge.

Two static select pins choose how the output behaves. One option sends the serialized data push-pull. A second option routes the raw serial input straight through. A third option sends the serialized data as an open-drain line that can only pull low. The fourth pin combination is not a valid setting: it falls back to push-pull serialized data and raises an error flag. A mute input forces a driven low in every option. The block does not model the pad itself. It presents a data value `sd_out` and a drive enable `sd_oe`, and the pad resolves them.

The serializer is a five-state machine clocked on the falling bit-clock edge:
- IDLE is entered on reset. It captures the frame clock and moves to SYNC on the next edge.
- SYNC waits for the first frame-clock change. On that change it goes to SHIFT when the format's start position is zero, and to WAIT otherwise.
- WAIT counts up to the start position, then goes to SHIFT.
- SHIFT loads the word at the start position and sends its bits. It goes to PAD when the word is exhausted, or to WAIT when a new half-frame begins before the start position is reached.
- PAD sends zeros until the next start position, then goes back to SHIFT.

Top module: `audio_tx_bypass`

## Requirements
- R1: While `rst_n` is low, and after its release until the first change of `lrck`, the serialized bit is 0. In push-pull mode this means `sd_out`=0 and `sd_oe`=1.
- R2: Left-justified framing (`fmt_sel`=1, and also the unused code 3) sends the MSB in the first bit period of a half-frame. The remaining bits follow one per period, and zeros fill the rest of the slot. In left- and right-justified framing, `lrck`=1 marks the left half.
- R3: Right-justified framing (`fmt_sel`=0) places the LSB in the last bit period of the half-frame, with zeros before the MSB.
- R4: I2S framing (`fmt_sel`=2) sends the MSB one bit period after the `lrck` change, and `lrck`=0 marks the left half. In 16-bit mode the LSB therefore falls in the first period of the following half-frame.
- R5: With `wide`=1 each half-frame is 32 bit periods and carries all 24 bits of the word. With `wide`=0 each half-frame is 16 periods and carries `word[23:8]`.
- R6: The serialized bit changes only on the falling edge of `bclk`. Each bit is valid across the following rising edge.
- R7: With `od_sel`=0 and `bypass`=0, `sd_oe`=1 and `sd_out` equals the serialized bit.
- R8: With `od_sel`=0 and `bypass`=1, `sd_oe`=1 and `sd_out` follows `ser_in` combinationally.
- R9: With `od_sel`=1 and `bypass`=0, `sd_out`=0 and `sd_oe` is 1 exactly when the serialized bit is 0. The line is released for a 1.
- R10: With `od_sel`=1 and `bypass`=1, the output behaves as in R7 and `cfg_err`=1. In every other combination `cfg_err`=0.
- R11: While `mute`=1, `sd_out`=0 and `sd_oe`=1 in every output mode.
- R12: The word for a half-frame is taken from `word_l` or `word_r` at the falling edge that launches its MSB. Later changes of those inputs do not alter the bits being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; all state changes on its falling edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lrck | input | 1 | Frame clock marking left and right halves |
| fmt_sel | input | 2 | Framing: 0 right-justified, 1 left-justified, 2 I2S, 3 as left-justified |
| wide | input | 1 | 1: 24-bit words in 32-clock halves; 0: 16-bit words in 16-clock halves |
| word_l | input | 24 | Left word to send, MSB aligned |
| word_r | input | 24 | Right word to send, MSB aligned |
| ser_in | input | 1 | Raw serial input used by the bypass route |
| od_sel | input | 1 | Open-drain select |
| bypass | input | 1 | Bypass select |
| mute | input | 1 | Forces a driven low on the output |
| sd_out | output | 1 | Output data value |
| sd_oe | output | 1 | Output drive enable |
| cfg_err | output | 1 | High when the unused select combination is applied |

## Verification
The bench targets the points where framing goes wrong quietly. The first is the 16-bit I2S LSB that spills into the next half-frame; a design that clears the shifter at the frame-clock change would send 0 there. The second is the 8-clock lead-in of 24-bit right-justified framing; a design that starts at the slot boundary would shift every bit 8 places early. Word inputs are scrambled on every bit period except the load period, so a design that reads the word late sends corrupted bits. Open-drain release, bypass passthrough, mute and the unused select combination are each compared at the pins on every bit, and an open-drain stage that drives highs or a reserved setting that leaves the pin floating shows up at once.

// File: rtl/audio_tx_pkg.sv
`timescale 1ns/1ps
package audio_tx_pkg;

    // framing codes as applied on fmt_sel
    typedef enum logic [1:0] {
        FMT_RJ  = 2'd0,
        FMT_LJ  = 2'd1,
        FMT_I2S = 2'd2,
        FMT_ALT = 2'd3
    } fmt_e;

    // serializer states
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SYNC  = 3'd1,
        ST_WAIT  = 3'd2,
        ST_SHIFT = 3'd3,
        ST_PAD   = 3'd4
    } tx_state_e;

    // output modes, encoded as {od_sel, bypass}
    typedef enum logic [1:0] {
        OM_PUSH     = 2'd0,
        OM_BYPASS   = 2'd1,
        OM_DRAIN    = 2'd2,
        OM_RESERVED = 2'd3
    } out_mode_e;

endpackage

// File: rtl/atx_frame_track.sv
`timescale 1ns/1ps
module atx_frame_track
    import audio_tx_pkg::*;
#(
    parameter int SLOT_WIDE   = 32,
    parameter int SLOT_NARROW = 16,
    localparam int POS_W      = $clog2(SLOT_WIDE)
) (
    input  logic             bclk,
    input  logic             rst_n,
    input  logic             lrck,
    input  logic             wide,
    input  fmt_e             fmt,
    input  logic             armed,
    output logic             lr_edge,
    output logic [POS_W-1:0] pos_cur,
    output logic             left_half
);

    localparam logic [POS_W-1:0] LAST_WIDE   = POS_W'(SLOT_WIDE - 1);
    localparam logic [POS_W-1:0] LAST_NARROW = POS_W'(SLOT_NARROW - 1);

    logic             lr_q;
    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] slot_last;

    // frame clock as seen at the previous falling edge, and bit position
    always_ff @(negedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            lr_q <= 1'b0;
            pos  <= '0;
        end else begin
            lr_q <= lrck;
            pos  <= pos_cur;
        end
    end

    always_comb begin
        slot_last = wide ? LAST_WIDE : LAST_NARROW;
        lr_edge   = armed && (lrck != lr_q);
        if (lr_edge)
            pos_cur = '0;
        else if (pos == slot_last)
            pos_cur = pos;               // hold at slot end until the next change
        else
            pos_cur = pos + 1'b1;
        left_half = (fmt == FMT_I2S) ? !lrck : lrck;
    end

endmodule

// File: rtl/atx_tx_fsm.sv
`timescale 1ns/1ps
module atx_tx_fsm
    import audio_tx_pkg::*;
#(
    parameter int WORD_W      = 24,
    parameter int NARROW_W    = 16,
    parameter int SLOT_WIDE   = 32,
    parameter int SLOT_NARROW = 16,
    localparam int POS_W      = $clog2(SLOT_WIDE)
) (
    input  logic              bclk,
    input  logic              rst_n,
    input  fmt_e              fmt,
    input  logic              wide,
    input  logic              lr_edge,
    input  logic [POS_W-1:0]  pos_cur,
    input  logic              left_half,
    input  logic [WORD_W-1:0] word_l,
    input  logic [WORD_W-1:0] word_r,
    output logic              tx_bit,
    output tx_state_e         state,
    output logic              armed
);

    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [POS_W-1:0] RJ_WIDE_START   = POS_W'(SLOT_WIDE - WORD_W);
    localparam logic [POS_W-1:0] RJ_NARROW_START = POS_W'(SLOT_NARROW - NARROW_W);
    localparam logic [POS_W-1:0] I2S_START       = POS_W'(1);
    localparam logic [CNT_W-1:0] LEN_WIDE_M1     = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] LEN_NARROW_M1   = CNT_W'(NARROW_W - 1);

    tx_state_e         nxt;
    logic [WORD_W-1:0] sh;
    logic [CNT_W-1:0]  cnt;
    logic [POS_W-1:0]  start_pos;
    logic [CNT_W-1:0]  len_m1;
    logic [WORD_W-1:0] wsel;
    logic              run;
    logic              do_load;
    logic              do_shift;

    // start position per framing, word length, and next state
    always_comb begin
        unique case (fmt)
            FMT_RJ:  start_pos = wide ? RJ_WIDE_START : RJ_NARROW_START;
            FMT_I2S: start_pos = I2S_START;
            default: start_pos = '0;
        endcase
        len_m1 = wide ? LEN_WIDE_M1 : LEN_NARROW_M1;
        wsel   = left_half ? word_l : word_r;

        unique case (state)
            ST_IDLE: run = 1'b0;
            ST_SYNC: run = lr_edge;
            default: run = 1'b1;
        endcase

        do_load  = run && (pos_cur == start_pos);
        do_shift = run && !do_load && (state == ST_SHIFT) && (cnt != '0);

        if (!run)
            nxt = (state == ST_IDLE) ? ST_SYNC : state;
        else if (do_load || do_shift)
            nxt = ST_SHIFT;
        else if (pos_cur < start_pos)
            nxt = ST_WAIT;
        else
            nxt = ST_PAD;
    end

    // state register
    always_ff @(negedge bclk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    // output bit and shifter
    always_ff @(negedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            tx_bit <= 1'b0;
            sh     <= '0;
            cnt    <= '0;
        end else if (do_load) begin
            tx_bit <= wsel[WORD_W-1];
            sh     <= {wsel[WORD_W-2:0], 1'b0};
            cnt    <= len_m1;
        end else if (do_shift) begin
            tx_bit <= sh[WORD_W-1];
            sh     <= {sh[WORD_W-2:0], 1'b0};
            cnt    <= cnt - 1'b1;
        end else begin
            tx_bit <= 1'b0;
        end
    end

    assign armed = (state != ST_IDLE);

endmodule

// File: rtl/atx_out_stage.sv
`timescale 1ns/1ps
module atx_out_stage
    import audio_tx_pkg::*;
(
    input  logic od_sel,
    input  logic bypass,
    input  logic mute,
    input  logic tx_bit,
    input  logic ser_in,
    output logic sd_out,
    output logic sd_oe,
    output logic cfg_err
);

    out_mode_e mode;

    always_comb begin
        mode    = out_mode_e'({od_sel, bypass});
        cfg_err = (mode == OM_RESERVED);
        if (mute) begin
            sd_out = 1'b0;
            sd_oe  = 1'b1;
        end else begin
            unique case (mode)
                OM_BYPASS: begin
                    sd_out = ser_in;
                    sd_oe  = 1'b1;
                end
                OM_DRAIN: begin
                    sd_out = 1'b0;
                    sd_oe  = !tx_bit;
                end
                default: begin               // push-pull and the fallback
                    sd_out = tx_bit;
                    sd_oe  = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/audio_tx_bypass.sv
`timescale 1ns/1ps
module audio_tx_bypass
    import audio_tx_pkg::*;
#(
    parameter int WORD_W      = 24,
    parameter int NARROW_W    = 16,
    parameter int SLOT_WIDE   = 32,
    parameter int SLOT_NARROW = 16
) (
    input  logic              bclk,
    input  logic              rst_n,
    input  logic              lrck,
    input  logic [1:0]        fmt_sel,
    input  logic              wide,
    input  logic [WORD_W-1:0] word_l,
    input  logic [WORD_W-1:0] word_r,
    input  logic              ser_in,
    input  logic              od_sel,
    input  logic              bypass,
    input  logic              mute,
    output logic              sd_out,
    output logic              sd_oe,
    output logic              cfg_err
);

    localparam int POS_W = $clog2(SLOT_WIDE);

    fmt_e             fmt;
    logic             lr_edge;
    logic [POS_W-1:0] pos_cur;
    logic             left_half;
    logic             armed;
    logic             tx_bit;
    tx_state_e        fsm_state;

    assign fmt = fmt_e'(fmt_sel);

    atx_frame_track #(
        .SLOT_WIDE   (SLOT_WIDE),
        .SLOT_NARROW (SLOT_NARROW)
    ) u_track (
        .bclk      (bclk),
        .rst_n     (rst_n),
        .lrck      (lrck),
        .wide      (wide),
        .fmt       (fmt),
        .armed     (armed),
        .lr_edge   (lr_edge),
        .pos_cur   (pos_cur),
        .left_half (left_half)
    );

    atx_tx_fsm #(
        .WORD_W      (WORD_W),
        .NARROW_W    (NARROW_W),
        .SLOT_WIDE   (SLOT_WIDE),
        .SLOT_NARROW (SLOT_NARROW)
    ) u_fsm (
        .bclk      (bclk),
        .rst_n     (rst_n),
        .fmt       (fmt),
        .wide      (wide),
        .lr_edge   (lr_edge),
        .pos_cur   (pos_cur),
        .left_half (left_half),
        .word_l    (word_l),
        .word_r    (word_r),
        .tx_bit    (tx_bit),
        .state     (fsm_state),
        .armed     (armed)
    );

    atx_out_stage u_out (
        .od_sel  (od_sel),
        .bypass  (bypass),
        .mute    (mute),
        .tx_bit  (tx_bit),
        .ser_in  (ser_in),
        .sd_out  (sd_out),
        .sd_oe   (sd_oe),
        .cfg_err (cfg_err)
    );

endmodule

// File: rtl/audio_tx_bypass_chk.sv
`timescale 1ns/1ps
module audio_tx_bypass_chk
    import audio_tx_pkg::*;
(
    input logic      bclk,
    input logic      rst_n,
    input logic      ser_in,
    input logic      od_sel,
    input logic      bypass,
    input logic      mute,
    input logic      sd_out,
    input logic      sd_oe,
    input logic      cfg_err,
    input logic      lr_edge,
    input logic      tx_bit,
    input tx_state_e state
);

    // R11: mute drives low whatever the mode
    a_r11_mute_low: assert property (@(posedge bclk) disable iff (!rst_n)
        mute |-> (!sd_out && sd_oe));

    // R9: the open-drain line never drives high
    a_r9_drain_low_only: assert property (@(posedge bclk) disable iff (!rst_n)
        (od_sel && !bypass && !mute) |-> !(sd_oe && sd_out));

    // R8: bypass passes the raw serial input and drives it
    a_r8_bypass_follow: assert property (@(posedge bclk) disable iff (!rst_n)
        (!od_sel && bypass && !mute) |-> (sd_oe && (sd_out == ser_in)));

    // R10: the fallback setting keeps the pin driven
    a_r10_reserved_drives: assert property (@(posedge bclk) disable iff (!rst_n)
        cfg_err |-> sd_oe);

    // R1: nothing but zeros before the first frame edge
    a_r1_quiet_before_frame: assert property (@(posedge bclk) disable iff (!rst_n)
        ((state == ST_IDLE) || (state == ST_SYNC)) |-> !tx_bit);

    // R1: a frame edge seen by the tracker always arms the serializer
    a_r1_edge_arms: assert property (@(negedge bclk) disable iff (!rst_n)
        lr_edge |=> ((state != ST_IDLE) && (state != ST_SYNC)));

endmodule

bind audio_tx_bypass audio_tx_bypass_chk u_chk (
    .bclk    (bclk),
    .rst_n   (rst_n),
    .ser_in  (ser_in),
    .od_sel  (od_sel),
    .bypass  (bypass),
    .mute    (mute),
    .sd_out  (sd_out),
    .sd_oe   (sd_oe),
    .cfg_err (cfg_err),
    .lr_edge (lr_edge),
    .tx_bit  (tx_bit),
    .state   (fsm_state)
);

// File: tb/sim_audio_tx_bypass.sv
`timescale 1ns/1ps
module sim_audio_tx_bypass;

    localparam int CLK_PERIOD = 10;

    logic        bclk = 1'b0;
    logic        rst_n;
    logic        lrck;
    logic [1:0]  fmt_sel;
    logic        wide;
    logic [23:0] word_l;
    logic [23:0] word_r;
    logic        ser_in;
    logic        od_sel;
    logic        bypass;
    logic        mute;
    logic        sd_out;
    logic        sd_oe;
    logic        cfg_err;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    audio_tx_bypass u0 (
        .bclk    (bclk),
        .rst_n   (rst_n),
        .lrck    (lrck),
        .fmt_sel (fmt_sel),
        .wide    (wide),
        .word_l  (word_l),
        .word_r  (word_r),
        .ser_in  (ser_in),
        .od_sel  (od_sel),
        .bypass  (bypass),
        .mute    (mute),
        .sd_out  (sd_out),
        .sd_oe   (sd_oe),
        .cfg_err (cfg_err)
    );

    always #(CLK_PERIOD/2) bclk = ~bclk;

    // compare {oe,out} pairs
    task automatic expect2(input string req, input logic [1:0] got,
                           input logic [1:0] exp, input int where);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s at %0d: got oe/out %b expected %b", req, where, got, exp);
        end
    endtask

    // drive one bit period: inputs after the rising edge, sample after the falling one (R6)
    task automatic step(input logic lr, input logic [23:0] wl, input logic [23:0] wr,
                        input logic ser);
        @(posedge bclk);
        #2;
        lrck   = lr;
        word_l = wl;
        word_r = wr;
        ser_in = ser;
        @(negedge bclk);
        #2;
    endtask

    // expected {oe,out} from the mode rules R7 to R11
    function automatic logic [1:0] pins(input logic b, input logic ser);
        if (mute)                 return 2'b10;
        else if (od_sel && !bypass) return {!b, 1'b0};
        else if (!od_sel && bypass) return {1'b1, ser};
        else                      return {1'b1, b};
    endfunction

    // expected serialized bit from the framing rules R2 to R5
    function automatic logic frame_bit(input int p, input int s, input int w,
                                       input logic [23:0] cur, input logic [23:0] prev,
                                       input bit prev_ok);
        if (fmt_sel == 2'd2) begin
            if (p >= 1 && p <= w) return cur[24-p];
            if (p == 0 && w == s && prev_ok) return prev[24-w];
            return 1'b0;
        end else if (fmt_sel == 2'd0) begin
            if (p >= s - w) return cur[23-(p-(s-w))];
            return 1'b0;
        end else begin
            if (p < w) return cur[23-p];
            return 1'b0;
        end
    endfunction

    function automatic logic left_level();
        return (fmt_sel == 2'd2) ? 1'b0 : 1'b1;
    endfunction

    task automatic reset_dut(input bit check_it);
        rst_n = 1'b0;
        for (int i = 0; i < 2; i++) begin
            step(!left_level(), 24'($urandom), 24'($urandom), 1'b0);
            if (check_it) expect2("R1 in reset", {sd_oe, sd_out}, 2'b10, i);
        end
        rst_n = 1'b1;
    endtask

    task automatic run_stream(input string tag, input int frames);
        int s;
        int w;
        int start;
        logic [23:0] prev;
        bit prev_ok;
        s = wide ? 32 : 16;
        w = wide ? 24 : 16;
        start = (fmt_sel == 2'd0) ? (s - w) : ((fmt_sel == 2'd2) ? 1 : 0);
        prev = '0;
        prev_ok = 0;
        expect2("R10 flag", {1'b0, cfg_err}, {1'b0, od_sel & bypass}, 0);
        for (int i = 0; i < 3; i++) begin
            step(!left_level(), 24'($urandom), 24'($urandom), 1'b0);
            expect2({tag, " R1 idle"}, {sd_oe, sd_out}, pins(1'b0, 1'b0), i);
        end
        for (int f = 0; f < frames; f++) begin
            for (int h = 0; h < 2; h++) begin
                logic [23:0] cur;
                cur = 24'($urandom);
                for (int p = 0; p < s; p++) begin
                    logic [23:0] wl;
                    logic [23:0] wr;
                    logic ser;
                    logic b;
                    // R12: inputs scrambled except in the load period
                    wl  = 24'($urandom);
                    wr  = 24'($urandom);
                    ser = 1'($urandom);
                    if (p == start) begin
                        if (h == 0) wl = cur;
                        else        wr = cur;
                    end
                    step((h == 0) ? left_level() : !left_level(), wl, wr, ser);
                    b = frame_bit(p, s, w, cur, prev, prev_ok);
                    expect2(tag, {sd_oe, sd_out}, pins(b, ser), f * 64 + h * 32 + p);
                end
                prev = cur;
                prev_ok = 1;
            end
        end
    endtask

    task automatic scenario(input string tag, input logic [1:0] f, input logic wd,
                            input logic od, input logic bp, input logic mu);
        fmt_sel = f;
        wide    = wd;
        od_sel  = od;
        bypass  = bp;
        mute    = mu;
        reset_dut(1'b0);
        run_stream(tag, 3);
    endtask

    task automatic t_reset();
        fmt_sel = 2'd1; wide = 1'b1; od_sel = 1'b0; bypass = 1'b0; mute = 1'b0;
        reset_dut(1'b1);
    endtask
    task automatic t_lj_wide();    scenario("R2 R5 R6 R7 R12 lj24",  2'd1, 1'b1, 1'b0, 1'b0, 1'b0); endtask
    task automatic t_rj_wide();    scenario("R3 R5 R12 rj24",        2'd0, 1'b1, 1'b0, 1'b0, 1'b0); endtask
    task automatic t_i2s_wide();   scenario("R4 R5 R12 i2s24",       2'd2, 1'b1, 1'b0, 1'b0, 1'b0); endtask
    task automatic t_lj_narrow();  scenario("R2 R5 lj16",            2'd1, 1'b0, 1'b0, 1'b0, 1'b0); endtask
    task automatic t_rj_narrow();  scenario("R3 R5 rj16",            2'd0, 1'b0, 1'b0, 1'b0, 1'b0); endtask
    task automatic t_i2s_narrow(); scenario("R4 R5 i2s16 wrap",      2'd2, 1'b0, 1'b0, 1'b0, 1'b0); endtask
    task automatic t_code3();      scenario("R2 code3",              2'd3, 1'b1, 1'b0, 1'b0, 1'b0); endtask
    task automatic t_drain();      scenario("R9 drain",              2'd2, 1'b1, 1'b1, 1'b0, 1'b0); endtask
    task automatic t_bypass();     scenario("R8 bypass",             2'd1, 1'b1, 1'b0, 1'b1, 1'b0); endtask
    task automatic t_reserved();   scenario("R10 fallback",          2'd0, 1'b0, 1'b1, 1'b1, 1'b0); endtask
    task automatic t_mute_push();  scenario("R11 mute push",         2'd1, 1'b1, 1'b0, 1'b0, 1'b1); endtask
    task automatic t_mute_drain(); scenario("R11 mute drain",        2'd2, 1'b0, 1'b1, 1'b0, 1'b1); endtask
    task automatic t_mute_bypass(); scenario("R11 mute bypass",      2'd1, 1'b1, 1'b0, 1'b1, 1'b1); endtask

    initial begin
        rst_n = 1'b0; lrck = 1'b0; fmt_sel = 2'd1; wide = 1'b1;
        word_l = '0; word_r = '0; ser_in = 1'b0;
        od_sel = 1'b0; bypass = 1'b0; mute = 1'b0;
        t_reset();
        t_lj_wide();
        t_rj_wide();
        t_i2s_wide();
        t_lj_narrow();
        t_rj_narrow();
        t_i2s_narrow();
        t_code3();
        t_drain();
        t_bypass();
        t_reserved();
        t_mute_push();
        t_mute_drain();
        t_mute_bypass();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not end, got running expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule